// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Timing

This block is an SPI master that shifts 8-bit words out and in while it controls the timing of its active-low chip-select line. A setup count sets how long chip-select is low before the first clock rise. A release count sets how long it stays low after the last clock fall. Between words, chip-select stays high for at least two peripheral clocks. A word-delay count can be added to that gap. A keep-select option holds chip-select low across words that follow each other closely, so a multi-byte frame comes out as one transaction.

Software programs three registers through a simple write port. Words enter through a valid/full handshake with a one-word holding register. Each received word appears on a data output, marked by a one-cycle valid pulse. All timing counts are in peripheral clock cycles.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, chip-select is high, SCLK is low, `tx_full` is 0 and `rx_valid` is 0. Register map: address 0 holds the setup count in bits [31:24] and the release count in [23:16]. Address 1 holds the divider in [7:0], the word-delay count in [15:8] and timer-disable in bit 18. Address 2 holds keep-select in bit 0, word-delay enable in bit 1 and master mode in bit 2. All fields reset to 0 except master mode, which resets to 1.
- R2: Each word is 8 bits, sent MSB first in SPI mode 0. MOSI changes only on SCLK falls. MISO is sampled on SCLK rises. The received byte appears on `rx_data` with a one-cycle `rx_valid` pulse.
- R3: With D = max(divider, 2), every SCLK low phase lasts floor(D/2) cycles and every high phase lasts D - floor(D/2) cycles.
- R4: With timer-disable at 0, the first SCLK rise comes S + floor(D/2) cycles after chip-select falls, where S is the setup count.
- R5: With timer-disable at 0, chip-select rises T cycles after the last SCLK fall of a transaction, where T is the release count. T = 0 releases on the same edge.
- R6: With timer-disable at 1, the setup and release counts are treated as 0.
- R7: When word delay is off and the next word is already waiting, chip-select stays high for exactly 2 cycles between transactions.
- R8: When word delay is enabled and master mode is 1, chip-select stays high for exactly W + 2 cycles between transactions, where W is the word-delay count.
- R9: When master mode is 0, the word-delay enable has no effect and the gap is 2 cycles.
- R10: If no word is waiting when the gap ends, chip-select stays high until a word arrives. It then falls one cycle after the word is accepted.
- R11: With keep-select at 1, a word that is waiting when the current word ends follows without a chip-select rise or setup delay. The release delay and the gap apply only after the last word.
- R12: `tx_full` rises when a word is accepted and clears when the sequencer takes the word. An offer made while `tx_full` is 1 is dropped and never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 8 | Transmit word |
| tx_full | output | 1 | Holding register occupied |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_data` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The gap between transactions is hard to pin down from the ports. The gap gets longer whenever the next word arrives late, so the exact W + 2 value shows only if the holding register refills while the current word is still shifting. The stimulus therefore queues every word as soon as `tx_full` drops. A separate directed case holds a word back until the gap has expired, to show the stretched case. Randomised configurations combine the divider, the setup, release and word-delay counts, timer-disable, keep-select and master mode. A slave model in the bench drives MISO and timestamps every chip-select and SCLK edge.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int CNT_W = 8;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_TIMING = 2'd0;
  localparam logic [ADDR_W-1:0] A_FORMAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  // field positions
  localparam int SETUP_LSB = 24;
  localparam int REL_LSB = 16;
  localparam int DIV_LSB = 0;
  localparam int WDLY_LSB = 8;
  localparam int TDIS_BIT = 18;
  localparam int KEEP_BIT = 0;
  localparam int WDEN_BIT = 1;
  localparam int MAST_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_REL,
    ST_GAP
  } seq_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] release_cnt;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] wdelay;
    logic tdis;
    logic keep;
    logic wd_en;
    logic master;
  } cfg_t;
endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output cfg_t              cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cfg_q.master <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        A_TIMING: begin
          cfg_q.setup <= wr_data[SETUP_LSB +: CNT_W];
          cfg_q.release_cnt <= wr_data[REL_LSB +: CNT_W];
        end
        A_FORMAT: begin
          cfg_q.div <= wr_data[DIV_LSB +: CNT_W];
          cfg_q.wdelay <= wr_data[WDLY_LSB +: CNT_W];
          cfg_q.tdis <= wr_data[TDIS_BIT];
        end
        A_CTRL: begin
          cfg_q.keep <= wr_data[KEEP_BIT];
          cfg_q.wd_en <= wr_data[WDEN_BIT];
          cfg_q.master <= wr_data[MAST_BIT];
        end
        default: ;
      endcase
    end
  end

  assign cfg = cfg_q;

  // R1
  master_reset_chk: assert property (@(posedge clk) $past(rst) |-> cfg_q.master && !cfg_q.wd_en && !cfg_q.keep);
endmodule

// File: rtl/spi_cs_txbuf.sv
module spi_cs_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (pop) begin
      full_q <= 1'b0;
    end else if (push_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= push_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R12
  held_word_chk: assert property (@(posedge clk) disable iff (rst)
    full_q && !pop |=> full_q && $stable(data_q));
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_t              cfg,
  input  logic              word_ready,
  input  logic [DATA_W-1:0] word_data,
  output logic              word_take,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CW = CNT_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  seq_state_t        state_q;
  logic [CW-1:0]     cnt_q;
  logic [CNT_W-1:0]  pcnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] txsh_q, rxsh_q, rx_q;
  logic              cs_n_q, sclk_q, rxv_q;

  logic [CNT_W-1:0] div_eff, lo_len, hi_len, setup_eff, rel_eff;
  logic [CW-1:0]    gap_len;
  logic             gap_done, launch, word_end, chain;

  always_comb begin
    div_eff = (cfg.div < CNT_W'(2)) ? CNT_W'(2) : cfg.div;
    lo_len = div_eff >> 1;
    hi_len = div_eff - lo_len;
    setup_eff = cfg.tdis ? '0 : cfg.setup;
    rel_eff = cfg.tdis ? '0 : cfg.release_cnt;
    gap_len = CW'(2) + ((cfg.wd_en && cfg.master) ? CW'(cfg.wdelay) : CW'(0));
    gap_done = (state_q == ST_GAP) && (cnt_q == '0);
    launch = word_ready && ((state_q == ST_IDLE) || gap_done);
    word_end = (state_q == ST_SHIFT) && sclk_q && (pcnt_q == '0) && (bit_q == LAST_BIT);
    chain = word_end && cfg.keep && word_ready;
  end

  assign word_take = launch || chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q <= '0;
      pcnt_q <= '0;
      bit_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      rx_q <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      rxv_q <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (launch) begin
        cs_n_q <= 1'b0;
        txsh_q <= word_data;
        bit_q <= '0;
        if (setup_eff == '0) begin
          state_q <= ST_SHIFT;
          pcnt_q <= lo_len - CNT_W'(1);
        end else begin
          state_q <= ST_SETUP;
          cnt_q <= CW'(setup_eff) - CW'(1);
        end
      end else begin
        case (state_q)
          ST_SETUP: begin
            if (cnt_q == '0) begin
              state_q <= ST_SHIFT;
              pcnt_q <= lo_len - CNT_W'(1);
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
          ST_SHIFT: begin
            if (pcnt_q != '0) begin
              pcnt_q <= pcnt_q - CNT_W'(1);
            end else if (!sclk_q) begin
              sclk_q <= 1'b1;
              pcnt_q <= hi_len - CNT_W'(1);
              rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q != LAST_BIT) begin
                bit_q <= bit_q + BIT_W'(1);
                txsh_q <= txsh_q << 1;
                pcnt_q <= lo_len - CNT_W'(1);
              end else begin
                rx_q <= rxsh_q;
                rxv_q <= 1'b1;
                if (chain) begin
                  txsh_q <= word_data;
                  bit_q <= '0;
                  pcnt_q <= lo_len - CNT_W'(1);
                end else if (rel_eff == '0) begin
                  cs_n_q <= 1'b1;
                  state_q <= ST_GAP;
                  cnt_q <= gap_len - CW'(1);
                end else begin
                  state_q <= ST_REL;
                  cnt_q <= CW'(rel_eff) - CW'(1);
                end
              end
            end
          end
          ST_REL: begin
            if (cnt_q == '0) begin
              cs_n_q <= 1'b1;
              state_q <= ST_GAP;
              cnt_q <= gap_len - CW'(1);
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
          ST_GAP: begin
            if (cnt_q == '0) state_q <= ST_IDLE;
            else cnt_q <= cnt_q - CW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = txsh_q[DATA_W-1];
  assign cs_n = cs_n_q;
  assign rx_data = rx_q;
  assign rx_valid = rxv_q;

  // R2
  clock_inside_select_chk: assert property (@(posedge clk) disable iff (rst) sclk_q |-> !cs_n_q);
  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst) rxv_q |=> !rxv_q);
  // R7
  min_gap_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n_q) |=> cs_n_q);
  // R4
  setup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETUP) |-> !cs_n_q && !sclk_q);
  // R11
  keep_low_chk: assert property (@(posedge clk) disable iff (rst) chain |=> !cs_n_q);
  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REL) |-> !cs_n_q && !sclk_q);
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  cfg_t              cfg;
  logic              buf_full, take;
  logic [DATA_W-1:0] buf_data;

  spi_cs_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .cfg(cfg)
  );

  spi_cs_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .push_valid(tx_valid), .push_data(tx_data),
    .pop(take), .full(buf_full), .data(buf_data)
  );

  spi_cs_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .word_ready(buf_full),
    .word_data(buf_data), .word_take(take), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign tx_full = buf_full;
endmodule

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
  logic clk = 0;
  logic rst = 1;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic tx_valid = 0;
  logic [7:0] tx_data = 0;
  logic tx_full;
  logic [7:0] rx_data;
  logic rx_valid;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 0;

  spi_cs_master i_spi_cs_master (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_full(tx_full), .rx_data(rx_data), .rx_valid(rx_valid),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // monitor and slave model state
  int fr_fall[16], fr_r1[16], fr_f1[16], fr_r2[16], fr_lf[16], fr_rise[16];
  int fr_nr[16], fr_nb[16];
  int nfr = 0;
  logic [7:0] mo_bytes[64];
  int mo_cnt = 0;
  logic [7:0] rx_b[64];
  int rx_cnt = 0;
  logic [7:0] sd[16];
  int swc = 0;
  int sbit = 0;
  int mbit = 0;
  logic [7:0] msh = 0;
  logic prev_cs = 1;
  logic prev_sclk = 0;

  always @(negedge clk) begin
    int fi;
    fi = nfr % 16;
    if (!rst) begin
      if (prev_cs && !spi_cs_n) begin
        fr_fall[fi] = cyc; fr_nr[fi] = 0; fr_nb[fi] = 0;
        mbit = 0; sbit = 0;
        spi_miso = sd[swc % 16][7];
      end
      if (!prev_sclk && spi_sclk) begin
        if (fr_nr[fi] == 0) fr_r1[fi] = cyc;
        if (fr_nr[fi] == 1) fr_r2[fi] = cyc;
        fr_nr[fi]++;
        msh = {msh[6:0], spi_mosi};
        mbit++;
        if (mbit == 8) begin
          mo_bytes[mo_cnt % 64] = msh; mo_cnt++; fr_nb[fi]++; mbit = 0;
        end
      end
      if (prev_sclk && !spi_sclk) begin
        if (fr_nr[fi] == 1) fr_f1[fi] = cyc;
        fr_lf[fi] = cyc;
        sbit++;
        if (sbit == 8) begin sbit = 0; swc++; end
        spi_miso = sd[swc % 16][7 - sbit];
      end
      if (!prev_cs && spi_cs_n) begin
        fr_rise[fi] = cyc; nfr++;
      end
      if (rx_valid) begin
        rx_b[rx_cnt % 64] = rx_data; rx_cnt++;
      end
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic push(input logic [7:0] b, output int t);
    @(negedge clk);
    while (tx_full) @(negedge clk);
    tx_valid = 1; tx_data = b;
    @(negedge clk);
    tx_valid = 0;
    t = cyc;
  endtask

  task automatic wait_frames(input int target);
    int k;
    k = 0;
    while (nfr < target && k < 20000) begin @(negedge clk); k++; end
    if (nfr < target) chk("R2 frame timeout", nfr, target);
  endtask

  function automatic int gap_of(input int w, input int wden, input int mst);
    return 2 + ((wden != 0 && mst != 0) ? w : 0);
  endfunction

  task automatic configure(input int div, input int s, input int t, input int w,
                           input int tdis, input int keep, input int wden, input int mst);
    logic [31:0] v;
    wreg(2'd0, {s[7:0], t[7:0], 16'h0});
    v = {13'b0, tdis[0], 2'b0, w[7:0], div[7:0]};
    wreg(2'd1, v);
    wreg(2'd2, {29'b0, mst[0], wden[0], keep[0]});
  endtask

  task automatic run_test(input int div, input int s, input int t, input int w,
                          input int tdis, input int keep, input int wden, input int mst,
                          input int n);
    int d, lo, hi, se, te, g, nf, fb, mb, rb, sb, ta;
    logic [7:0] words[4];
    string tg_s, tg_t, tg_g, tg_n;
    d = (div < 2) ? 2 : div;
    lo = d / 2; hi = d - lo;
    se = tdis ? 0 : s; te = tdis ? 0 : t;
    g = gap_of(w, wden, mst);
    tg_s = tdis ? "R6 setup" : "R4 setup";
    tg_t = tdis ? "R6 release" : "R5 release";
    tg_g = wden ? (mst ? "R8 gap" : "R9 gap") : "R7 gap";
    tg_n = keep ? "R11 words/frame" : "R2 words/frame";
    configure(div, s, t, w, tdis, keep, wden, mst);
    fb = nfr; mb = mo_cnt; rb = rx_cnt; sb = swc;
    for (int i = 0; i < n; i++) begin
      words[i] = 8'($urandom);
      sd[(sb + i) % 16] = 8'($urandom);
    end
    for (int i = 0; i < n; i++) push(words[i], ta);
    nf = keep ? 1 : n;
    wait_frames(fb + nf);
    repeat (g + 4) @(negedge clk);
    for (int k = 0; k < nf; k++) begin
      int fi;
      fi = (fb + k) % 16;
      chk(tg_s, fr_r1[fi] - fr_fall[fi], se + lo);
      chk("R3 high phase", fr_f1[fi] - fr_r1[fi], hi);
      chk("R3 low phase", fr_r2[fi] - fr_f1[fi], lo);
      chk(tg_t, fr_rise[fi] - fr_lf[fi], te);
      chk(tg_n, fr_nb[fi], keep ? n : 1);
      if (k > 0) chk(tg_g, fr_fall[fi] - fr_rise[(fb + k - 1) % 16], g);
    end
    chk("R2 mosi count", mo_cnt - mb, n);
    for (int i = 0; i < n; i++) begin
      chk("R2 mosi byte", mo_bytes[(mb + i) % 64], words[i]);
      chk("R2 rx byte", rx_b[(rb + i) % 64], sd[(sb + i) % 16]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ta, tb, fb, mb, fi;
    int seed_val;
    seed_val = $urandom(20240611);
    for (int i = 0; i < 16; i++) sd[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sclk", spi_sclk, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_valid", rx_valid, 0);

    // directed corners
    run_test(2, 0, 0, 0, 0, 0, 0, 1, 2);   // R7 tightest timing
    run_test(4, 3, 5, 4, 0, 0, 1, 1, 3);   // R8
    run_test(4, 3, 5, 4, 0, 0, 1, 0, 2);   // R9
    run_test(3, 7, 6, 9, 1, 0, 0, 1, 2);   // R6
    run_test(5, 2, 3, 3, 0, 1, 1, 1, 3);   // R11
    run_test(0, 20, 17, 30, 0, 0, 1, 1, 2); // R3 divider clamp, long delays

    // R10: late word stretches the gap, cs falls one cycle after accept
    configure(2, 0, 0, 0, 0, 0, 0, 1);
    fb = nfr;
    push(8'h5A, ta);
    wait_frames(fb + 1);
    repeat (15) @(negedge clk);
    push(8'hC3, tb);
    wait_frames(fb + 2);
    repeat (6) @(negedge clk);
    fi = (fb + 1) % 16;
    chk("R10 cs fall after accept", fr_fall[fi] - tb, 1);
    chk("R10 stretched gap", (fr_fall[fi] - fr_rise[fb % 16]) > 2, 1);

    // R12: offers while full are dropped
    fb = nfr; mb = mo_cnt;
    push(8'h81, ta);
    push(8'h7E, tb);
    chk("R12 full after accept", tx_full, 1);
    tx_valid = 1; tx_data = 8'h3C;
    repeat (4) @(negedge clk);
    chk("R12 still full", tx_full, 1);
    tx_valid = 0;
    wait_frames(fb + 2);
    repeat (40) @(negedge clk);
    chk("R12 frame count", nfr - fb, 2);
    chk("R12 byte count", mo_cnt - mb, 2);
    chk("R12 first byte", mo_bytes[mb % 64], 8'h81);
    chk("R12 second byte", mo_bytes[(mb + 1) % 64], 8'h7E);
    chk("R12 full cleared", tx_full, 0);

    // constrained random
    for (int it = 0; it < 25; it++) begin
      int dv, s, t, w, td, kp, we, ms, n;
      dv = 2 + int'($urandom % 5);
      s = int'($urandom % 6);
      t = int'($urandom % 6);
      w = int'($urandom % 7);
      td = int'($urandom % 2);
      kp = int'($urandom % 2);
      we = int'($urandom % 2);
      ms = (($urandom % 4) != 0) ? 1 : 0;
      n = 1 + int'($urandom % 3);
      run_test(dv, s, t, w, td, kp, we, ms, n);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule